// File: doc/BRIEF.md
# Interrupt Pending-State Tracker

This block holds one pending bit per interrupt ID for a parameterised number of IDs. It is meant to sit between the pins and the register bank of an interrupt distributor. IDs 0 to 15 are software-only lines. IDs 16 to 31 are the private range: five hardwired private inputs occupy IDs 27 to 31, and IDs 16 to 26 are not implemented. Every ID from 32 upward is a shared line driven by one bit of `spi_pin`.

External inputs pass through a two-flop synchroniser and are then converted to an active-high "asserted" form. Each line's two-bit configuration field decides how the pending bit is set: either it follows the asserted level, or it latches on a rising edge. The register bank can set or clear pending bits with one-cycle pulses. A per-line acknowledge pulse clears pending bits on edge-style lines. Two words give the synchronised pin levels, so software can see the true pin state whatever the pending bits hold.

The block also drives the configuration field of every ID, so that a register bank can return it when read.

Top module: `irq_pend_tracker`

## Requirements
- R1: After reset, `pend_out`, `ppi_status` and `spi_status` are all zero.
- R2: `cfg_out[2*i+1:2*i]` holds the field for ID i. The values are:
  - 2'b10 for IDs 0–15.
  - 2'b01 for private inputs 0, 1 and 4 (IDs 27, 28, 31).
  - 2'b11 for private inputs 2 and 3 (IDs 29, 30).
  - 2'b00 for IDs 16–26.
  - {`spi_edge_sel[s]`, 1'b1} for shared line s (ID 32+s).
- R3: Private inputs 0, 1 and 4 are level-sensitive. Input 0 is active-high; inputs 1 and 4 are active-low. While `dist_en`=1, the pending bit equals the asserted level three clock edges after the pin changes.
- R4: An edge-sensitive line (private inputs 2 and 3, or a shared line with `spi_edge_sel`=1) sets its pending bit on a rising pin edge. The bit stays set after the pin falls, until a clear pulse or an acknowledge arrives.
- R5: A shared line with `spi_edge_sel`=0 is active-high level-sensitive: its pending bit follows the pin while `dist_en`=1.
- R6: While `dist_en`=0, pin changes neither set nor clear any pending bit.
- R7: A shared line with `spi_tgt_nz`=0 never becomes pending, neither from its pin nor from `sw_set_pend`.
- R8: A `sw_set_pend` pulse sets the bit at the next edge and a `sw_clr_pend` pulse clears it. If both hit the same line in the same cycle, the bit ends up set.
- R9: A `line_ack` pulse clears the pending bit of edge-style lines, including IDs 0–15. It has no effect on level-sensitive lines.
- R10: `ppi_status[15:11]` gives the synchronised raw levels of `ppi_pin[4:0]`, two edges after the pins change, and all other bits read zero. The word does not depend on any pending state.
- R11: `spi_status[s]` gives the synchronised raw level of `spi_pin[s]`, two edges after the pin changes.
- R12: IDs 16–26 never become pending, whatever the software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global enable for pin-driven pending changes |
| ppi_pin | input | 5 | Private interrupt inputs, mixed polarity |
| spi_pin | input | NUM_IRQ-32 | Shared interrupt inputs, active-high |
| spi_edge_sel | input | NUM_IRQ-32 | Upper config bit per shared line (1 = rising edge) |
| spi_tgt_nz | input | NUM_IRQ-32 | Target field of the shared line is non-zero |
| sw_set_pend | input | NUM_IRQ | Software set-pending pulses |
| sw_clr_pend | input | NUM_IRQ | Software clear-pending pulses |
| line_ack | input | NUM_IRQ | Acknowledge pulses, one per ID |
| pend_out | output | NUM_IRQ | Pending vector |
| cfg_out | output | 2*NUM_IRQ | Configuration field per ID |
| ppi_status | output | 32 | Raw private-input status word |
| spi_status | output | NUM_IRQ-32 | Raw shared-input status |

## Verification
The hardest state to reach is a pending bit that must stay frozen while its pin moves. This happens on a level line that was latched before `dist_en` dropped: the pin then falls while the enable is low. The stimulus reaches it by enabling first, letting a shared level line go pending, and then disabling. Only after that is the pin lowered, and the bench waits well past the synchroniser latency before checking that the bit still holds. Re-enabling then clears the bit within one edge. The same-cycle set/clear collision and an acknowledge on an asserted level line are also driven on purpose, since normal traffic seldom produces them.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int SGI_COUNT   = 16;
  localparam int PPI_COUNT   = 5;
  localparam int PPI_BASE_ID = 27;
  localparam int SPI_BASE_ID = 32;

  typedef enum logic [1:0] {
    CFG_NONE = 2'b00,
    CFG_LVL  = 2'b01,
    CFG_SGI  = 2'b10,
    CFG_EDGE = 2'b11
  } cfg_code_e;

  // per private input: 1 = active-low pin
  localparam logic [PPI_COUNT-1:0] PPI_ACT_LOW = 5'b10010;
  // per private input: 1 = rising-edge sensitive
  localparam logic [PPI_COUNT-1:0] PPI_EDGE    = 5'b01100;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvl_d
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl   = sync_q;
  assign lvl_d = prev_q;
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell #(
  parameter bit HAS_PIN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_en,
  input  logic edge_mode,
  input  logic hw_level,
  input  logic hw_rise,
  input  logic set_ok,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic ack,
  output logic pend
);
  logic pend_q, pend_d;
  logic hw_set, hw_drop, set_any, clr_any;

  always_comb begin
    hw_set  = HAS_PIN && hw_en && set_ok && (edge_mode ? hw_rise : hw_level);
    hw_drop = HAS_PIN && hw_en && !edge_mode && !hw_level;
    set_any = hw_set || (sw_set && set_ok);
    clr_any = sw_clr || (ack && edge_mode) || hw_drop;
    pend_d  = set_any || (pend_q && !clr_any);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && set_ok) |=> pend_q);

  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_en && !sw_set && !sw_clr && !ack) |=> $stable(pend_q));

  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_PIN && hw_en && !edge_mode && !hw_level && !sw_set) |=> !pend_q);

  p_no_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ok && !pend_q) |=> !pend_q);

  p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pend_q && !sw_clr && !ack) |=> pend_q);

  p_level_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && pend_q && !sw_clr && !hw_en) |=> pend_q);
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_pend_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dist_en,
  input  logic [4:0]             ppi_pin,
  input  logic [NUM_IRQ-33:0]    spi_pin,
  input  logic [NUM_IRQ-33:0]    spi_edge_sel,
  input  logic [NUM_IRQ-33:0]    spi_tgt_nz,
  input  logic [NUM_IRQ-1:0]     sw_set_pend,
  input  logic [NUM_IRQ-1:0]     sw_clr_pend,
  input  logic [NUM_IRQ-1:0]     line_ack,
  output logic [NUM_IRQ-1:0]     pend_out,
  output logic [2*NUM_IRQ-1:0]   cfg_out,
  output logic [31:0]            ppi_status,
  output logic [NUM_IRQ-33:0]    spi_status
);
  localparam int NUM_SPI = NUM_IRQ - SPI_BASE_ID;

  logic [PPI_COUNT-1:0] ppi_lvl, ppi_lvl_d;
  logic [NUM_SPI-1:0]   spi_lvl, spi_lvl_d;

  irq_pin_sync #(.WIDTH(PPI_COUNT)) u_ppi_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(ppi_pin), .lvl(ppi_lvl), .lvl_d(ppi_lvl_d));

  irq_pin_sync #(.WIDTH(NUM_SPI)) u_spi_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(spi_pin), .lvl(spi_lvl), .lvl_d(spi_lvl_d));

  assign ppi_status = {16'b0, ppi_lvl, 11'b0};
  assign spi_status = spi_lvl;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    if (i < SGI_COUNT) begin : g_sgi
      irq_pend_cell #(.HAS_PIN(1'b0)) u_cell (
        .clk(clk), .rst_n(rst_n), .hw_en(1'b0), .edge_mode(1'b1),
        .hw_level(1'b0), .hw_rise(1'b0), .set_ok(1'b1),
        .sw_set(sw_set_pend[i]), .sw_clr(sw_clr_pend[i]), .ack(line_ack[i]),
        .pend(pend_out[i]));
      assign cfg_out[2*i +: 2] = CFG_SGI;
    end else if (i >= PPI_BASE_ID && i < SPI_BASE_ID) begin : g_ppi
      localparam int K = i - PPI_BASE_ID;
      logic asserted, asserted_d;
      assign asserted   = ppi_lvl[K]   ^ PPI_ACT_LOW[K];
      assign asserted_d = ppi_lvl_d[K] ^ PPI_ACT_LOW[K];
      irq_pend_cell #(.HAS_PIN(1'b1)) u_cell (
        .clk(clk), .rst_n(rst_n), .hw_en(dist_en), .edge_mode(PPI_EDGE[K]),
        .hw_level(asserted), .hw_rise(asserted && !asserted_d), .set_ok(1'b1),
        .sw_set(sw_set_pend[i]), .sw_clr(sw_clr_pend[i]), .ack(line_ack[i]),
        .pend(pend_out[i]));
      assign cfg_out[2*i +: 2] = PPI_EDGE[K] ? CFG_EDGE : CFG_LVL;
    end else if (i >= SPI_BASE_ID) begin : g_spi
      localparam int S = i - SPI_BASE_ID;
      irq_pend_cell #(.HAS_PIN(1'b1)) u_cell (
        .clk(clk), .rst_n(rst_n), .hw_en(dist_en), .edge_mode(spi_edge_sel[S]),
        .hw_level(spi_lvl[S]), .hw_rise(spi_lvl[S] && !spi_lvl_d[S]),
        .set_ok(spi_tgt_nz[S]),
        .sw_set(sw_set_pend[i]), .sw_clr(sw_clr_pend[i]), .ack(line_ack[i]),
        .pend(pend_out[i]));
      assign cfg_out[2*i +: 2] = {spi_edge_sel[S], 1'b1};
    end else begin : g_none
      logic unused_inputs;
      assign unused_inputs = sw_set_pend[i] | sw_clr_pend[i] | line_ack[i];
      assign pend_out[i] = 1'b0;
      assign cfg_out[2*i +: 2] = CFG_NONE;
    end
  end

  p_status_tracks_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(spi_pin) |=> ##1 (spi_status == $past(spi_pin, 2)));
endmodule

// File: tb/irq_pend_tracker_bench.sv
module irq_pend_tracker_bench;
  localparam int N = 64;
  localparam int S = N - 32;

  logic clk = 1'b0;
  logic rst_n;
  logic dist_en;
  logic [4:0] ppi_pin;
  logic [S-1:0] spi_pin, spi_edge_sel, spi_tgt_nz;
  logic [N-1:0] sw_set_pend, sw_clr_pend, line_ack, pend_out;
  logic [2*N-1:0] cfg_out;
  logic [31:0] ppi_status;
  logic [S-1:0] spi_status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_pend_tracker #(.NUM_IRQ(N)) u_irq_pend_tracker (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .ppi_pin(ppi_pin),
    .spi_pin(spi_pin), .spi_edge_sel(spi_edge_sel), .spi_tgt_nz(spi_tgt_nz),
    .sw_set_pend(sw_set_pend), .sw_clr_pend(sw_clr_pend), .line_ack(line_ack),
    .pend_out(pend_out), .cfg_out(cfg_out), .ppi_status(ppi_status),
    .spi_status(spi_status));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_set(input int id);
    sw_set_pend[id] = 1'b1; step(1); sw_set_pend[id] = 1'b0;
  endtask
  task automatic pulse_clr(input int id);
    sw_clr_pend[id] = 1'b1; step(1); sw_clr_pend[id] = 1'b0;
  endtask
  task automatic pulse_ack(input int id);
    line_ack[id] = 1'b1; step(1); line_ack[id] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pend", pend_out, 64'h0);
    chk("R1 ppi_status", {32'h0, ppi_status}, 64'h0);
    chk("R1 spi_status", {32'h0, spi_status}, 64'h0);
  endtask

  task automatic t_cfg;
    chk("R2 sgi cfg", {62'h0, cfg_out[2*3 +: 2]}, 64'h2);
    chk("R12 unimpl cfg", {62'h0, cfg_out[2*20 +: 2]}, 64'h0);
    chk("R2 ppi cfg", {54'h0, cfg_out[2*31 +: 2], cfg_out[2*30 +: 2],
        cfg_out[2*29 +: 2], cfg_out[2*28 +: 2], cfg_out[2*27 +: 2]}, 64'h1F5);
    chk("R2 spi level cfg", {62'h0, cfg_out[2*33 +: 2]}, 64'h1);
    chk("R2 spi edge cfg", {62'h0, cfg_out[2*40 +: 2]}, 64'h3);
  endtask

  task automatic t_ppi_level;
    ppi_pin[0] = 1'b1; step(3);
    chk("R3 ppi0 high pend", pend_out[27], 1);
    ppi_pin[0] = 1'b0; step(3);
    chk("R3 ppi0 low clear", pend_out[27], 0);
    ppi_pin[1] = 1'b0; step(3);
    chk("R3 ppi1 active-low pend", pend_out[28], 1);
    ppi_pin[1] = 1'b1; step(3);
    chk("R3 ppi1 release", pend_out[28], 0);
    chk("R3 ppi4 idle high not pending", pend_out[31], 0);
  endtask

  task automatic t_ppi_status;
    chk("R10 idle status", {32'h0, ppi_status}, 64'h9000);
    pulse_set(27);
    chk("R10 status after sw set", {32'h0, ppi_status}, 64'h9000);
    ppi_pin[3] = 1'b1; step(2);
    chk("R10 status follows pin", {32'h0, ppi_status}, 64'hD000);
    ppi_pin[3] = 1'b0; step(3);
    pulse_clr(30);
  endtask

  task automatic t_edge;
    ppi_pin[2] = 1'b1; step(3);
    chk("R4 ppi2 rise pend", pend_out[29], 1);
    ppi_pin[2] = 1'b0; step(3);
    chk("R4 ppi2 hold after fall", pend_out[29], 1);
    pulse_ack(29);
    chk("R9 ack clears edge", pend_out[29], 0);
    spi_pin[8] = 1'b1; step(3);
    chk("R4 spi edge pend", pend_out[40], 1);
    spi_pin[8] = 1'b0; step(3);
    chk("R4 spi edge hold", pend_out[40], 1);
    pulse_clr(40);
    chk("R4 clear pulse", pend_out[40], 0);
  endtask

  task automatic t_spi_level;
    spi_pin[1] = 1'b1; step(3);
    chk("R5 spi level pend", pend_out[33], 1);
    chk("R11 spi status", spi_status[1], 1);
    pulse_ack(33);
    chk("R9 ack ignored on level", pend_out[33], 1);
    spi_pin[1] = 1'b0; step(3);
    chk("R5 spi level clear", pend_out[33], 0);
    chk("R11 spi status low", spi_status[1], 0);
  endtask

  task automatic t_disable;
    dist_en = 1'b0;
    spi_pin[2] = 1'b1; step(4);
    chk("R6 no set while disabled", pend_out[34], 0);
    dist_en = 1'b1; step(1);
    chk("R6 set after enable", pend_out[34], 1);
    dist_en = 1'b0;
    spi_pin[2] = 1'b0; step(4);
    chk("R6 frozen while disabled", pend_out[34], 1);
    dist_en = 1'b1; step(1);
    chk("R6 clear after enable", pend_out[34], 0);
  endtask

  task automatic t_target;
    spi_tgt_nz[3] = 1'b0;
    spi_pin[3] = 1'b1; step(3);
    chk("R7 pin blocked", pend_out[35], 0);
    pulse_set(35);
    chk("R7 sw set blocked", pend_out[35], 0);
    spi_pin[3] = 1'b0; step(3);
    spi_tgt_nz[3] = 1'b1;
  endtask

  task automatic t_sw;
    pulse_set(5);
    chk("R8 sw set", pend_out[5], 1);
    sw_set_pend[6] = 1'b1; sw_clr_pend[6] = 1'b1; step(1);
    sw_set_pend[6] = 1'b0; sw_clr_pend[6] = 1'b0;
    chk("R8 set wins", pend_out[6], 1);
    pulse_clr(5);
    chk("R8 sw clear", pend_out[5], 0);
    pulse_ack(6);
    chk("R9 ack clears sgi", pend_out[6], 0);
    pulse_set(20);
    chk("R12 unimplemented stays clear", pend_out[20], 0);
  endtask

  initial begin
    rst_n = 1'b0; dist_en = 1'b0; ppi_pin = 5'b10010;
    spi_pin = '0; spi_edge_sel = '0; spi_edge_sel[8] = 1'b1; spi_tgt_nz = '1;
    sw_set_pend = '0; sw_clr_pend = '0; line_ack = '0;
    step(3);
    t_reset;
    rst_n = 1'b1;
    step(4);
    dist_en = 1'b1;
    step(1);
    chk("R1 idle pend after enable", pend_out, 64'h0);
    t_cfg;
    t_ppi_level;
    t_ppi_status;
    t_edge;
    t_spi_level;
    t_disable;
    t_target;
    t_sw;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule